// File: doc/BRIEF.md
# Single-Target Interrupt Gateway and Claim/Complete Controller

This block gathers a small set of external interrupt lines for one interrupt target. Every line first passes through its own gateway, which turns the line into a pending bit. A line can be treated as level-high or as rising-edge. An arbiter picks the best pending source from those that are enabled and have a nonzero priority. The target's request output goes high when that source's priority is above a programmable threshold.

Software works through a small register port. A read of the claim address returns the winning source ID and takes that source: its pending bit clears and it becomes in flight. Writing the same ID back to the claim address completes it. A gateway forwards nothing more for a source while that source is in flight.

An edge-mode gateway keeps no count of edges. Any rising edge that arrives while the source is pending or in flight is lost. Software that must not miss edges therefore completes right after the claim and only then runs its handler.

Top module: `pintc_slice`

## Requirements
- R1: After reset the request output is low, every configuration register reads 0, and a claim read returns 0.
- R2: The trigger register (address 0x03) holds one bit per source: bit i-1 for source i. A 1 selects rising-edge mode and a 0 selects level-high mode. Input lines pass through two synchronizing flops, so a pending bit appears on the third rising clock edge after the line changes.
- R3: The request output is high exactly when the highest priority among pending, enabled sources with nonzero priority is strictly greater than the threshold (address 0x02, bits 2:0). A threshold of 7 masks every source, and a priority of 0 never requests.
- R4: Arbitration picks the highest priority. On equal priority the lowest source ID wins. Source IDs run from 1 to NUM_SRC.
- R5: A read of address 0x00 returns the winning ID in the read data on the cycle after the read strobe. It returns 0 when the request output is low. The same read clears that source's pending bit and marks the source in flight.
- R6: A write of an ID to address 0x00 ends that source's in-flight state. The write is ignored when the source is not in flight, when it is disabled, or when the ID is 0 or above NUM_SRC.
- R7: In edge mode each low-to-high transition makes a source pending once. Edges that arrive while the source is pending or in flight are dropped, and no count of them is kept.
- R8: In level mode a source becomes pending again after its completion if its line is still high.
- R9: An in-flight source is never pending and is not offered again until its completion.
- R10: The enable register (address 0x01) holds bit i-1 for source i. The priority of source i sits at address 0x10+i in bits 2:0. Every configuration register reads back the value that was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_lines | input | NUM_SRC | Asynchronous interrupt lines; bit i-1 is source i |
| reg_rd | input | 1 | Read strobe; a read of the claim address claims the winning source |
| reg_wr | input | 1 | Write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data, valid the cycle after reg_rd |
| irq_req | output | 1 | Interrupt request to the target |

## Verification
The assertions check on every cycle the invariants of a gateway:
- a source is never pending and in flight at once;
- a claim always leaves its source in flight;
- a completion always releases it;
- a threshold of 7 keeps the request low;
- a claim read made while the request is low returns 0.

Other behaviour only shows over a sequence of register accesses, so only the bench's scenarios can show it:
- edges lost while a source is in flight;
- a level source asserting again after completion;
- completions of disabled sources being ignored;
- tie-breaking on the lowest ID.

The bench also checks these against a model driven by random line activity.

// File: rtl/pintc_pkg.sv
// Package: shared types and the register address map of the interrupt slice.
// Assumes: priority width of 3 bits; addresses fit in 8 bits.
package pintc_pkg;
    localparam int PRIO_W = 3;
    typedef logic [PRIO_W-1:0] prio_t;
    localparam prio_t PRIO_MAX = '1;

    localparam logic [7:0] ADDR_CLAIM     = 8'h00;
    localparam logic [7:0] ADDR_ENABLE    = 8'h01;
    localparam logic [7:0] ADDR_THRESH    = 8'h02;
    localparam logic [7:0] ADDR_TRIGGER   = 8'h03;
    localparam logic [7:0] ADDR_PRIO_BASE = 8'h10;
endpackage

// File: rtl/pintc_gateway.sv
// Module: one source gateway. Synchronizes the line, detects rising edges
// and holds the pending and in-flight state of the source.
// Assumes: claim_hit is only raised while pending is set; claim and
// completion never target the same source in one cycle.
module pintc_gateway (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_line,
    input  logic edge_mode,
    input  logic claim_hit,
    input  logic complete_hit,
    output logic pending,
    output logic in_flight
);
    logic sync_a, sync_b, line_prev;
    logic rise, trigger;

    // Two-flop synchronizer plus delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_a    <= 1'b0;
            sync_b    <= 1'b0;
            line_prev <= 1'b0;
        end else begin
            sync_a    <= irq_line;
            sync_b    <= sync_a;
            line_prev <= sync_b;
        end
    end

    // Trigger condition selected by the source's mode.
    always_comb begin
        rise    = sync_b & ~line_prev;
        trigger = edge_mode ? rise : sync_b;
    end

    // Pending and in-flight state: claim takes the source, completion releases it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending   <= 1'b0;
            in_flight <= 1'b0;
        end else if (claim_hit) begin
            pending   <= 1'b0;
            in_flight <= 1'b1;
        end else begin
            if (complete_hit)
                in_flight <= 1'b0;
            if (!in_flight && !pending && trigger)
                pending <= 1'b1;
        end
    end

    // R9: never pending while in flight
    a_r9_no_pend_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
        !(pending && in_flight));
    // R5: a claim leaves the source in flight and not pending
    a_r5_claim_takes: assert property (@(posedge clk) disable iff (!rst_n)
        claim_hit |=> (in_flight && !pending));
    // R6: a completion releases the source
    a_r6_complete_frees: assert property (@(posedge clk) disable iff (!rst_n)
        complete_hit |=> !in_flight);
endmodule

// File: rtl/pintc_arbiter.sv
// Module: combinational arbiter. Finds the highest-priority eligible source;
// the lowest ID wins a tie. Assumes IDs start at 1 (index 0 is source 1).
module pintc_arbiter
    import pintc_pkg::*;
#(
    parameter int NUM_SRC = 8,
    localparam int ID_W = $clog2(NUM_SRC + 1)
) (
    input  logic [NUM_SRC-1:0] pending,
    input  logic [NUM_SRC-1:0] enable,
    input  prio_t              prio [NUM_SRC],
    output logic [ID_W-1:0]    best_id,
    output prio_t              best_prio
);
    // Scan from the top ID down so that ties fall to the lower ID.
    always_comb begin
        best_prio = '0;
        best_id   = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (pending[i] && enable[i] && prio[i] != '0 && prio[i] >= best_prio) begin
                best_prio = prio[i];
                best_id   = ID_W'(i + 1);
            end
        end
    end

    // R4: a nonzero winning priority always names a source
    always_comb begin
        a_r4_winner_named: assert (best_prio == '0 || best_id != '0);
    end
endmodule

// File: rtl/pintc_regs.sv
// Module: register port. Holds the configuration, decodes claim reads and
// completion writes, and returns registered read data.
// Assumes: one source may be claimed per cycle; a read and a write may share a cycle.
module pintc_regs
    import pintc_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32,
    localparam int ID_W = $clog2(NUM_SRC + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_rd,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    input  logic               irq_req,
    input  logic [ID_W-1:0]    best_id,
    input  logic [NUM_SRC-1:0] in_flight,
    output prio_t              threshold,
    output logic [NUM_SRC-1:0] enable,
    output logic [NUM_SRC-1:0] edge_mode,
    output prio_t              prio [NUM_SRC],
    output logic [NUM_SRC-1:0] claim_vec,
    output logic [NUM_SRC-1:0] complete_vec
);
    logic              hit_claim;
    logic [DATA_W-1:0] rd_next;

    // Address decode of the claim/complete register.
    always_comb hit_claim = (reg_addr == ADDR_W'(ADDR_CLAIM));

    // One-hot claim and qualified completion strobes per source.
    always_comb begin
        for (int i = 0; i < NUM_SRC; i++) begin
            claim_vec[i]    = reg_rd && hit_claim && irq_req && (best_id == ID_W'(i + 1));
            complete_vec[i] = reg_wr && hit_claim && (reg_wdata == DATA_W'(i + 1))
                              && in_flight[i] && enable[i];
        end
    end

    // Configuration register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            threshold <= '0;
            enable    <= '0;
            edge_mode <= '0;
            for (int i = 0; i < NUM_SRC; i++) prio[i] <= '0;
        end else if (reg_wr) begin
            if (reg_addr == ADDR_W'(ADDR_THRESH))  threshold <= reg_wdata[PRIO_W-1:0];
            if (reg_addr == ADDR_W'(ADDR_ENABLE))  enable    <= reg_wdata[NUM_SRC-1:0];
            if (reg_addr == ADDR_W'(ADDR_TRIGGER)) edge_mode <= reg_wdata[NUM_SRC-1:0];
            for (int i = 0; i < NUM_SRC; i++)
                if (reg_addr == ADDR_W'(ADDR_PRIO_BASE) + ADDR_W'(i + 1))
                    prio[i] <= reg_wdata[PRIO_W-1:0];
        end
    end

    // Read data multiplexer.
    always_comb begin
        rd_next = '0;
        if (hit_claim)
            rd_next = irq_req ? DATA_W'(best_id) : '0;
        else if (reg_addr == ADDR_W'(ADDR_THRESH))
            rd_next = DATA_W'(threshold);
        else if (reg_addr == ADDR_W'(ADDR_ENABLE))
            rd_next = DATA_W'(enable);
        else if (reg_addr == ADDR_W'(ADDR_TRIGGER))
            rd_next = DATA_W'(edge_mode);
        for (int i = 0; i < NUM_SRC; i++)
            if (reg_addr == ADDR_W'(ADDR_PRIO_BASE) + ADDR_W'(i + 1))
                rd_next = DATA_W'(prio[i]);
    end

    // Registered read data, updated on each read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= rd_next;
    end

    // R5: a claim read with no request returns 0
    a_r5_idle_claim_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && hit_claim && !irq_req) |=> (reg_rdata == '0));
    // R5: at most one source claimed per read
    a_r5_single_claim: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(claim_vec));
endmodule

// File: rtl/pintc_slice.sv
// Module: top of the single-target interrupt slice. Connects the register
// port, one gateway per source and the arbiter, and drives the request.
// Assumes: NUM_SRC <= DATA_W and the priority addresses fit in ADDR_W.
module pintc_slice
    import pintc_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32,
    localparam int ID_W = $clog2(NUM_SRC + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_lines,
    input  logic               reg_rd,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic               irq_req
);
    prio_t              threshold;
    prio_t              prio [NUM_SRC];
    prio_t              best_prio;
    logic [ID_W-1:0]    best_id;
    logic [NUM_SRC-1:0] enable, edge_mode, pending, in_flight, claim_vec, complete_vec;

    pintc_regs #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_req(irq_req), .best_id(best_id), .in_flight(in_flight),
        .threshold(threshold), .enable(enable), .edge_mode(edge_mode),
        .prio(prio), .claim_vec(claim_vec), .complete_vec(complete_vec)
    );

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_gw
        pintc_gateway u_gw (
            .clk(clk), .rst_n(rst_n), .irq_line(irq_lines[g]),
            .edge_mode(edge_mode[g]), .claim_hit(claim_vec[g]),
            .complete_hit(complete_vec[g]), .pending(pending[g]),
            .in_flight(in_flight[g])
        );
    end

    pintc_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
        .pending(pending), .enable(enable), .prio(prio),
        .best_id(best_id), .best_prio(best_prio)
    );

    // Request to the target: winner strictly above the threshold.
    always_comb irq_req = (best_prio > threshold);

    // R3: threshold at maximum masks every source
    a_r3_full_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (threshold == PRIO_MAX) |-> !irq_req);
    // R4: a raised request always has a winning ID
    a_r4_req_has_id: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (best_id != '0));
endmodule

// File: tb/pintc_slice_tb.sv
module pintc_slice_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 8;
    localparam int AW = 8;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] irq_lines = '0;
    logic          reg_rd = 1'b0, reg_wr = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          irq_req;

    int checks = 0, fails = 0;
    bit finished = 0;

    // model state, index 1..NS
    int m_prio [NS+1];
    bit m_en [NS+1], m_edge [NS+1], m_pend [NS+1], m_infl [NS+1], m_line [NS+1];
    int m_thr;

    pintc_slice #(.NUM_SRC(NS), .ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .reg_rd(reg_rd),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_req(irq_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int best_prio_m();
        int bp = 0;
        for (int i = NS; i >= 1; i--)
            if (m_pend[i] && m_en[i] && m_prio[i] != 0 && m_prio[i] >= bp) bp = m_prio[i];
        return bp;
    endfunction

    function automatic int winner_m();
        int bp = 0, bid = 0;
        for (int i = NS; i >= 1; i--)
            if (m_pend[i] && m_en[i] && m_prio[i] != 0 && m_prio[i] >= bp) begin
                bp = m_prio[i]; bid = i;
            end
        return (bp > m_thr) ? bid : 0;
    endfunction

    function automatic void settle_levels();
        for (int i = 1; i <= NS; i++)
            if (!m_edge[i] && m_line[i] && !m_infl[i]) m_pend[i] = 1;
    endfunction

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input int addr, input int data);
        @(negedge clk);
        reg_wr = 1; reg_addr = AW'(addr); reg_wdata = DW'(data);
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(input int addr, output int data);
        @(negedge clk);
        reg_rd = 1; reg_addr = AW'(addr);
        @(posedge clk); #1;
        data = int'(reg_rdata);
        @(negedge clk);
        reg_rd = 0;
    endtask

    task automatic set_lines(input logic [NS-1:0] v);
        @(negedge clk);
        irq_lines = v;
        cycles(4);
        for (int i = 1; i <= NS; i++) begin
            if (m_edge[i] && v[i-1] && !m_line[i] && !m_infl[i]) m_pend[i] = 1;
            m_line[i] = v[i-1];
        end
        settle_levels();
    endtask

    task automatic cfg_prio(input int id, input int p);
        wr(8'h10 + id, p); m_prio[id] = p;
    endtask

    task automatic cfg_en(input logic [NS-1:0] v);
        wr(8'h01, int'(v));
        for (int i = 1; i <= NS; i++) m_en[i] = v[i-1];
    endtask

    task automatic cfg_thr(input int t);
        wr(8'h02, t); m_thr = t;
    endtask

    // claim and compare against model; returns the claimed id
    task automatic claim(input string tag, output int got);
        int exp;
        exp = winner_m();
        check(int'(irq_req), int'(best_prio_m() > m_thr), {tag, " R3 request"});
        rd(8'h00, got);
        check(got, exp, {tag, " R5 claim id"});
        if (exp != 0) begin m_pend[exp] = 0; m_infl[exp] = 1; end
        cycles(1);
    endtask

    task automatic complete(input int id);
        wr(8'h00, id);
        if (id >= 1 && id <= NS && m_infl[id] && m_en[id]) m_infl[id] = 0;
        cycles(2);
        settle_levels();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : main
        int v, got;
        for (int i = 0; i <= NS; i++) begin
            m_prio[i] = 0; m_en[i] = 0; m_edge[i] = 0;
            m_pend[i] = 0; m_infl[i] = 0; m_line[i] = 0;
        end
        m_thr = 0;
        cycles(3);
        @(negedge clk) rst_n = 1;
        cycles(1);

        // R1 reset state
        check(int'(irq_req), 0, "R1 request after reset");
        rd(8'h02, v); check(v, 0, "R1 threshold after reset");
        rd(8'h01, v); check(v, 0, "R1 enable after reset");
        rd(8'h13, v); check(v, 0, "R1 priority after reset");
        rd(8'h00, v); check(v, 0, "R1 claim after reset");

        // R10 readback
        cfg_prio(1, 2); cfg_prio(2, 5); cfg_prio(3, 5); cfg_prio(4, 6);
        wr(8'h03, 8'h08);  // source 4 edge (R2 bit 3)
        m_edge[4] = 1;
        cfg_en(8'h0F);
        rd(8'h12, v); check(v, 5, "R10 priority readback");
        rd(8'h03, v); check(v, 8, "R10 trigger readback");
        rd(8'h01, v); check(v, 15, "R10 enable readback");

        // R4 tie: sources 2 and 3 at priority 5, lowest id wins
        set_lines(8'b0000_0110);
        claim("R4 tie", got); check(got, 2, "R4 lowest id on tie");
        claim("R4 next", got); check(got, 3, "R4 second claim");
        complete(2); complete(3);
        set_lines(8'b0000_0000);
        claim("R8 level still high", got);  // both re-pended while high before drop
        complete(got);
        claim("R8 drain", got);
        complete(got);
        claim("R8 idle", got); check(got, 0, "R8 nothing after line low");

        // R7 edge source 4
        set_lines(8'b0000_1000);
        claim("R7 edge", got); check(got, 4, "R7 edge forwarded");
        set_lines(8'b0000_0000);
        set_lines(8'b0000_1000);  // edge while in flight: lost
        complete(4);
        claim("R7 lost", got); check(got, 0, "R7 edge in flight dropped");
        set_lines(8'b0000_0000);
        set_lines(8'b0000_1000);
        set_lines(8'b0000_0000);
        set_lines(8'b0000_1000);  // second edge while pending: no count
        claim("R7 once", got); check(got, 4, "R7 edge after completion");
        complete(4);
        claim("R7 no count", got); check(got, 0, "R7 extra edge not counted");
        set_lines(8'b0000_0000);

        // R8 level re-assert after completion
        set_lines(8'b0000_0001);
        claim("R8 a", got); check(got, 1, "R8 level claim");
        claim("R9 b", got); check(got, 0, "R9 in flight not offered");
        complete(1);
        claim("R8 c", got); check(got, 1, "R8 re-pending while high");

        // R6 completion ignored when disabled, wrong id, or zero
        cfg_en(8'h0E);
        complete(1); complete(0); complete(NS + 1);
        cfg_en(8'h0F);
        claim("R6 ignored", got); check(got, 0, "R6 disabled completion ignored");
        complete(1);
        claim("R6 works", got); check(got, 1, "R6 completion releases source");
        complete(1);

        // R3 threshold masking
        cfg_thr(7);
        check(int'(irq_req), 0, "R3 threshold 7 masks");
        claim("R3 mask", got); check(got, 0, "R3 masked claim zero");
        cfg_thr(1);
        claim("R3 strict", got); check(got, 1, "R3 priority 2 above 1");
        cfg_thr(2);
        complete(1);
        check(int'(irq_req), 0, "R3 equal priority not above");
        cfg_thr(0);
        set_lines(8'b0000_0000);
        claim("R3 drain", got); complete(got);

        // random phase
        void'($urandom(32'd4321));
        wr(8'h03, 8'hA8);
        for (int i = 1; i <= NS; i++) m_edge[i] = (8'hA8 >> (i-1)) & 1;
        for (int i = 1; i <= NS; i++) cfg_prio(i, int'($urandom_range(0, 7)));
        cfg_en(8'hFF);
        for (int it = 0; it < 400; it++) begin
            int op;
            op = int'($urandom_range(0, 9));
            if (op < 4)       set_lines(NS'($urandom()));
            else if (op < 7)  claim("R4 random", got);
            else if (op < 9)  complete(int'($urandom_range(0, NS + 1)));
            else if ($urandom_range(0, 1) == 0) cfg_thr(int'($urandom_range(0, 4)));
            else              cfg_en(NS'($urandom() | 32'h3));
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule